// File: doc/BRIEF.md
# Stochastic AND-Inverter Chain Generator

This block emits one pseudo-random bit per clock. Over time, the fraction of ones in the stream approaches a target probability, which may be any decimal fraction. The value is built by a programmable chain of stages. The chain starts from a constant one, which has probability 1. Each stage then either complements the running stream or ANDs it with its own independent random source. That source has probability 0.4 or 0.5. A complement maps p to 1-p. An AND with an independent source maps p to p·q. With these two operations, about three AND stages and three complements per decimal digit reach any decimal target.

Software or a host computes the stage program elsewhere and writes it one stage at a time. A stage count selects how many stages, counted from the innermost one (stage 0), take part. Every stage owns a 16-bit maximal-length LFSR. Each LFSR is seeded from the shared seed input, mixed with the stage index, so no two stages draw from the same source.

Top module: `sgen_chain`

## Requirements
- R1: While rst_ni is low, and after reset for as long as en_i is low, bit_o is 0.
- R2: Stage op codes are 2'b00 complement, 2'b01 AND with the 0.4 source, 2'b10 AND with the 0.5 source, and 2'b11 pass. Stage 0 acts on a constant one, and stage i acts on the output of stage i-1.
- R3: Only stages with an index below stage_cnt_i are active, and any stage at or above it passes its input unchanged. A count of 0 therefore gives a constant-one stream, whatever the program holds.
- R4: bit_o is registered. It shows the chain result one clock after an edge where en_i is high, and it is 0 one clock after an edge where en_i is low.
- R5: Each stage has its own 16-bit LFSR. The LFSR loads a non-zero seed derived from seed_i and the stage index while en_i is low, and advances on every enabled clock. It never reaches the all-zero state. Its source bit is 1 when the state is below 26214 for the 0.4 source, or below 32768 for the 0.5 source.
- R6: When prog_we_i is high, a clock edge stores prog_data_i as the op code of stage prog_addr_i. Reset sets every stage to pass (2'b11).
- R7: The measured fraction of ones over 16384 enabled cycles matches the product-and-complement value of the active program to within 0.02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the chain. While low, the LFSRs are reseeded and the output is forced to 0 |
| prog_we_i | input | 1 | Program write strobe |
| prog_addr_i | input | 6 | Index of the stage to write |
| prog_data_i | input | 2 | Op code to store |
| stage_cnt_i | input | 6 | Number of active stages, counted from stage 0 |
| seed_i | input | 16 | Base seed for all stage LFSRs |
| bit_o | output | 1 | Output random bit stream |

## Verification
bit_o sits one register behind the chain, so every result is due exactly one clock after the edge that sampled en_i, the program and the stage count. The bench drives inputs on the falling edge and samples bit_o on the next falling edge, so the first sample after a change already reflects it. Program writes land at the clock edge that samples them. For this reason, programs are loaded with en_i low, and the first four enabled cycles are discarded before counting. Constant streams are checked cycle by cycle. Statistical targets are compared against a probability model that the bench computes from each program.

// File: rtl/sgen_pkg.sv
package sgen_pkg;
  typedef enum logic [1:0] {
    OP_INV    = 2'b00,
    OP_AND_LO = 2'b01,
    OP_AND_HI = 2'b10,
    OP_PASS   = 2'b11
  } op_e;
endpackage

// File: rtl/sgen_lfsr.sv
module sgen_lfsr #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] seed_nz;

  // zero is the lock-up state of an LFSR
  assign seed_nz = (seed_i == '0) ? W'(1) : seed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= W'(1);
    else if (load_i)  state_q <= seed_nz;
    else if (adv_i)   state_q <= state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
  end

  assign state_o = state_q;

  p_lfsr_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_lfsr_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> state_q != $past(state_q));
endmodule

// File: rtl/sgen_stage.sv
module sgen_stage
  import sgen_pkg::*;
#(
  parameter int unsigned  W      = 16,
  parameter logic [W-1:0] THR_LO = 16'd26214,
  parameter logic [W-1:0] THR_HI = 16'd32768
) (
  input  logic         in_i,
  input  logic         act_i,
  input  op_e          op_i,
  input  logic [W-1:0] rnd_i,
  output logic         out_o
);
  logic src_lo, src_hi;
  assign src_lo = rnd_i < THR_LO;
  assign src_hi = rnd_i < THR_HI;

  always_comb begin
    out_o = in_i;
    if (act_i) begin
      unique case (op_i)
        OP_INV:    out_o = ~in_i;
        OP_AND_LO: out_o = in_i & src_lo;
        OP_AND_HI: out_o = in_i & src_hi;
        default:   out_o = in_i;
      endcase
    end
  end
endmodule

// File: rtl/sgen_chain.sv
module sgen_chain
  import sgen_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 40,
  parameter int unsigned LFSR_W     = 16,
  localparam int unsigned ADDR_W    = $clog2(NUM_STAGES),
  localparam int unsigned CNT_W     = $clog2(NUM_STAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [1:0]        prog_data_i,
  input  logic [CNT_W-1:0]  stage_cnt_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic              bit_o
);
  localparam logic [LFSR_W-1:0] THR_LO = LFSR_W'((4 * (2 ** LFSR_W) + 5) / 10);
  localparam logic [LFSR_W-1:0] THR_HI = LFSR_W'(2 ** (LFSR_W - 1));
  localparam int unsigned       SEED_MIX = 40503;

  op_e                 prog_q [NUM_STAGES];
  logic [NUM_STAGES:0] link;
  logic                bit_q;

  assign link[0] = 1'b1;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic [LFSR_W-1:0] rnd;
    logic [LFSR_W-1:0] seed;
    logic              act;

    assign seed = seed_i ^ LFSR_W'((g + 1) * SEED_MIX);
    assign act  = CNT_W'(g) < stage_cnt_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     prog_q[g] <= OP_PASS;
      else if (prog_we_i && prog_addr_i == ADDR_W'(g)) prog_q[g] <= op_e'(prog_data_i);
    end

    sgen_lfsr #(.W(LFSR_W)) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (!en_i),
      .adv_i  (en_i),
      .seed_i (seed),
      .state_o(rnd)
    );

    sgen_stage #(.W(LFSR_W), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_stage (
      .in_i (link[g]),
      .act_i(act),
      .op_i (prog_q[g]),
      .rnd_i(rnd),
      .out_o(link[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bit_q <= 1'b0;
    else if (en_i)  bit_q <= link[NUM_STAGES];
    else            bit_q <= 1'b0;
  end

  assign bit_o = bit_q;

  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bit_o);
  p_empty_chain_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stage_cnt_i == '0 |=> bit_o);
endmodule

// File: tb/sgen_chain_tb.sv
module sgen_chain_tb;
  localparam int unsigned N_ST   = 40;
  localparam int unsigned WIN    = 16384;
  localparam real         TOL    = 0.02;
  localparam int unsigned N_VEC  = 8;

  typedef struct packed {
    logic [5:0]        cnt;
    logic [2*N_ST-1:0] prog;
    logic [15:0]       seed;
  } vec_t;

  // prog: stage i code at bits [2i+1:2i]; stages at or above cnt must be masked (R3)
  localparam vec_t VECS [N_VEC] = '{
    '{6'd1,  80'h1,       16'hACE1},  // 0.4
    '{6'd1,  80'h2,       16'h1234},  // 0.5
    '{6'd2,  80'h9,       16'h5A5A},  // 0.2
    '{6'd3,  80'h29,      16'hBEEF},  // 0.1
    '{6'd3,  80'h21,      16'h0F0F},  // 0.3
    '{6'd4,  80'h21,      16'h7777},  // 0.7
    '{6'd4,  80'h29,      16'hC0DE},  // 0.9
    '{6'd14, 80'h1228621, 16'h3141}   // 0.757
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic        we = 0;
  logic [5:0]  addr = '0;
  logic [1:0]  data = '0;
  logic [5:0]  cnt = '0;
  logic [15:0] seed = 16'h1;
  logic        bit_w;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sgen_chain u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .prog_we_i(we),
    .prog_addr_i(addr), .prog_data_i(data), .stage_cnt_i(cnt),
    .seed_i(seed), .bit_o(bit_w)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_prog(logic [2*N_ST-1:0] p);
    for (int i = 0; i < N_ST; i++) begin
      @(negedge clk);
      we = 1; addr = 6'(i); data = p[2*i +: 2];
    end
    @(negedge clk);
    we = 0;
  endtask

  task automatic count_ones(int cycles, output int ones);
    ones = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      ones += int'(bit_w);
    end
  endtask

  function automatic real model(logic [2*N_ST-1:0] p, int c);
    real v = 1.0;
    for (int i = 0; i < c; i++) begin
      case (p[2*i +: 2])
        2'b00: v = 1.0 - v;
        2'b01: v = v * 0.4;
        2'b10: v = v * 0.5;
        default: v = v;
      endcase
    end
    return v;
  endfunction

  initial begin
    int ones;
    // R1 reset
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'(bit_w), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'(bit_w), 0);

    // R6 reset leaves all stages in pass
    cnt = 6'd40; en = 1;
    count_ones(64, ones);
    chk("R6 reset program all pass", ones, 64);

    // R4 disable latency
    en = 0;
    @(negedge clk);
    chk("R4 zero one cycle after disable", int'(bit_w), 0);

    // R2 single complement stage
    load_prog(80'h0);
    cnt = 6'd1; en = 1;
    count_ones(64, ones);
    chk("R2 complement of one", ones, 0);

    // R3 count 0 masks the complement
    en = 0; cnt = 6'd0;
    @(negedge clk);
    en = 1;
    chk("R4 before enable edge", int'(bit_w), 0);
    @(negedge clk);
    chk("R4 one cycle after enable", int'(bit_w), 1);
    count_ones(63, ones);
    chk("R3 count zero gives ones", ones, 63);

    // R6 single-stage write; R2 pass code
    en = 0;
    @(negedge clk);
    we = 1; addr = 6'd0; data = 2'b11;
    @(negedge clk);
    we = 0; cnt = 6'd1; en = 1;
    count_ones(32, ones);
    chk("R6 R2 pass code written", ones, 32);

    // table walk: R7 R5 R2
    foreach (VECS[k]) begin
      real exp_p, got_p;
      en = 0;
      load_prog(VECS[k].prog);
      seed = VECS[k].seed;
      cnt = VECS[k].cnt;
      @(negedge clk);
      en = 1;
      repeat (4) @(negedge clk);
      count_ones(WIN, ones);
      exp_p = model(VECS[k].prog, int'(VECS[k].cnt));
      got_p = real'(ones) / real'(WIN);
      n_run++;
      if (got_p > exp_p + TOL || got_p < exp_p - TOL) begin
        n_fail++;
        $display("FAIL R7 vec %0d actual=%f expected=%f", k, got_p, exp_p);
      end
    end

    // R1 disabled again
    en = 0;
    @(negedge clk);
    count_ones(16, ones);
    chk("R1 idle stream", ones, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule